// File: doc/BRIEF.md
# FIFO-Steered NCO Desynchronizer

This block regenerates an evenly spaced output word rate for a constant-bit-rate payload that was pulled out of a larger transport frame. Payload words come in on the write clock in irregular bursts, each one marked by a valid strobe. They are stored in a dual-clock FIFO. On the read side a phase-accumulator oscillator produces a read tick, and each tick pulls one word out of the FIFO. The top bit of the accumulator is also driven out as a square-wave clock. External analog filtering of that clock lies outside this block.

The occupancy of the FIFO steers the oscillator. At a fixed interval the read side measures its fill level and takes the error against the half-full point. A proportional-plus-integral filter turns that error into a new tuning word. When the FIFO sits above the midpoint the output rate goes up, and when it sits below the midpoint the rate goes down. The output therefore follows a payload whose rate drifts by tens of ppm against the local clock. The integral term is clamped to a configurable ppm span around the nominal word.

After reset, reading waits until the FIFO is half full. Two sticky flags record the faults: a write lost to a full FIFO, and a read tick that found the FIFO empty.

Top module: `nco_desync`

## Requirements
- R1: A word is written only in a write-clock cycle with `wr_valid` high and the FIFO not full. Words leave on `rd_data` in the order they were written. Each read tick that finds the FIFO non-empty delivers exactly one word, flagged by `rd_valid` in the following cycle.
- R2: After reset, no word is read, `tune_word` equals `NOM_TW` and the oscillator is idle until `fill_level` reaches DEPTH/2. `rd_run` then rises and stays high until the next reset.
- R3: While running, the phase accumulator adds `tune_word` on every read-clock cycle. `nco_clk` is its most significant bit. One read tick is issued per 0-to-1 transition of that bit, so over a window the tick count equals the sum of the tuning words divided by 2^ACC_W, within one tick.
- R4: `fill_level` equals the number of words written, as seen through the pointer synchronizer, minus the number of words read. It is in the range 0 to DEPTH and settles at the exact written count once writing stops.
- R5: The first `tune_load` pulse comes exactly UPD_PERIOD read cycles after `rd_run` rises. Each later pulse comes exactly UPD_PERIOD cycles after the one before it.
- R6: At each load, err = fill − DEPTH/2 is taken from the fill level of the cycle before the load. The integrator becomes I + err·2^KI_SH, then clamped. `tune_word` becomes NOM_TW + err·2^KP_SH + I, so a positive error raises the rate.
- R7: `tune_word` does not change in any cycle without a `tune_load` pulse.
- R8: The integrator is clamped to ±floor(NOM_TW·RANGE_PPM/10^6). With the defaults this is ±69793. Under a FIFO held near full, the integrator reaches this limit.
- R9: `wr_ovf` is set by a valid write into a full FIFO. That word is dropped, and the flag stays set until reset.
- R10: `rd_udf` is set by a read tick that finds the FIFO empty. No `rd_valid` is produced for that tick, and the flag stays set until reset.
- R11: Reset clears both flags, both pointers and the integrator. It returns `tune_word` to `NOM_TW`, holds `nco_clk` low, and restarts the hold-off of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Marks a payload word on `wr_data` |
| wr_data | input | DW | Payload word |
| wr_ovf | output | 1 | Sticky overflow flag (write domain) |
| rd_clk | input | 1 | Read-side clock that runs the oscillator |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_valid | output | 1 | `rd_data` carries a word this cycle |
| rd_data | output | DW | Payload word drained from the FIFO |
| rd_run | output | 1 | Hold-off complete, reading enabled |
| rd_udf | output | 1 | Sticky underflow flag (read domain) |
| fill_level | output | AW+1 | Measured FIFO occupancy in the read domain |
| tune_word | output | ACC_W | Tuning word currently fed to the accumulator |
| tune_load | output | 1 | One-cycle pulse when a new tuning word is applied |
| nco_clk | output | 1 | Accumulator MSB, the generated output clock |

## Verification
The FIFO is filled with a short run of single writes to test the half-full hold-off. A four-in-sixteen burst pattern that matches the nominal read rate then checks word order and the tick rate predicted from the summed tuning words. Withholding all writes drives the FIFO empty. This exposes underflow and a negative error that walks the integrator down. A continuous write stream then holds the FIFO full and shows both overflow and the positive integrator clamp. During all of these phases, every tuning-word load is compared with an arithmetic model of the filter. That comparison separates errors in sign, gain shift, clamp limit and load timing.

// File: rtl/desync_pkg.sv
package desync_pkg;

   localparam int PPM_DEN = 1_000_000;

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/desync_sync.sv
module desync_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/desync_afifo.sv
module desync_afifo
   import desync_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ovf,
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          rd_tick,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          rd_udf,
   output logic [AW:0]   fill
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wbin, wgray, wbin_inc, rgray_w;
   logic [PW-1:0] rbin, rgray, rbin_inc, wgray_r, wbin_r;
   logic          full, empty;

   // write domain
   assign wbin_inc = wbin + PW'(1);
   assign full     = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         wr_ovf <= 1'b0;
      end else if (wr_valid) begin
         if (full) begin
            wr_ovf <= 1'b1;
         end else begin
            wbin  <= wbin_inc;
            wgray <= PW'(bin2gray(32'(wbin_inc)));
         end
      end
   end

   always_ff @(posedge wr_clk) begin
      if (wr_valid && !full) mem[wbin[AW-1:0]] <= wr_data;
   end

   desync_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w));

   desync_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r));

   // read domain
   assign wbin_r   = PW'(gray2bin(32'(wgray_r)));
   assign fill     = wbin_r - rbin;
   assign empty    = (fill == '0);
   assign rbin_inc = rbin + PW'(1);

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_udf   <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (rd_tick) begin
            if (empty) begin
               rd_udf <= 1'b1;
            end else begin
               rd_data  <= mem[rbin[AW-1:0]];
               rd_valid <= 1'b1;
               rbin     <= rbin_inc;
               rgray    <= PW'(bin2gray(32'(rbin_inc)));
            end
         end
      end
   end

   p_ovf_set_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_valid && full) |=> wr_ovf);
   p_ovf_sticky_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_ovf |=> wr_ovf);
   p_udf_set_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_tick && empty) |=> (rd_udf && !rd_valid));
   p_udf_sticky_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_udf |=> rd_udf);
   p_fill_max_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      fill <= PW'(DEPTH));
   p_valid_nonempty_r1: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_valid |-> $past(rd_tick && !empty));

endmodule

// File: rtl/desync_loop.sv
module desync_loop
   import desync_pkg::*;
#(
   parameter int     AW         = 4,
   parameter int     ACC_W      = 32,
   parameter longint NOM_TW     = 64'h4000_0000,
   parameter int     RANGE_PPM  = 65,
   parameter int     KP_SH      = 8,
   parameter int     KI_SH      = 7,
   parameter bit     INTEG_EN   = 1'b1,
   parameter int     UPD_PERIOD = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW:0]      fill,
   output logic             run,
   output logic [ACC_W-1:0] tune_word,
   output logic             tune_load
);

   localparam int                     MID   = 1 << (AW - 1);
   localparam int                     CW    = $clog2(UPD_PERIOD);
   localparam longint                 LIM_L = (NOM_TW * RANGE_PPM) / PPM_DEN;
   localparam logic signed [ACC_W:0]  LIM   = (ACC_W+1)'(LIM_L);
   localparam logic signed [ACC_W:0]  NOM_S = (ACC_W+1)'(NOM_TW);

   logic [CW-1:0]         cnt;
   logic                  fire;
   logic signed [ACC_W:0] err_w, p_term, integ, i_next, tw_calc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 run <= 1'b0;
      else if (!run && (fill >= (AW+1)'(MID)))    run <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cnt <= '0;
      else if (!run || cnt == CW'(UPD_PERIOD-1))  cnt <= '0;
      else                                        cnt <= cnt + CW'(1);
   end

   assign fire   = run && (cnt == CW'(UPD_PERIOD-1));
   assign err_w  = $signed((ACC_W+1)'(fill)) - $signed((ACC_W+1)'(MID));
   assign p_term = err_w <<< KP_SH;

   if (INTEG_EN) begin : g_pi
      logic signed [ACC_W:0] i_sum;
      assign i_sum  = integ + (err_w <<< KI_SH);
      assign i_next = (i_sum > LIM) ? LIM : ((i_sum < -LIM) ? -LIM : i_sum);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    integ <= '0;
         else if (fire) integ <= i_next;
      end

      p_integ_lim_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (integ <= LIM) && (integ >= -LIM));
   end else begin : g_p
      assign i_next = '0;
      assign integ  = '0;
   end

   assign tw_calc = NOM_S + p_term + i_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tune_word <= ACC_W'(NOM_TW);
         tune_load <= 1'b0;
      end else begin
         tune_load <= fire;
         if (fire) tune_word <= ACC_W'(tw_calc);
      end
   end

   p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run);
   p_idle_noload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!tune_load && tune_word == ACC_W'(NOM_TW)));
   p_load_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tune_load |=> !tune_load);
   p_tw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tune_load |-> $stable(tune_word));

endmodule

// File: rtl/desync_nco.sv
module desync_nco #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [ACC_W-1:0] step,
   output logic             tick,
   output logic             msb
);

   logic [ACC_W-1:0] acc, acc_next;

   assign acc_next = acc + step;
   assign msb      = acc[ACC_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         tick <= 1'b0;
      end else if (!en) begin
         acc  <= '0;
         tick <= 1'b0;
      end else begin
         acc  <= acc_next;
         tick <= !acc[ACC_W-1] && acc_next[ACC_W-1];
      end
   end

   p_tick_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (msb && !$past(msb)));
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!tick && !msb));

endmodule

// File: rtl/nco_desync.sv
module nco_desync #(
   parameter int     DW          = 8,
   parameter int     AW          = 4,
   parameter int     SYNC_STAGES = 2,
   parameter int     ACC_W       = 32,
   parameter longint NOM_TW      = 64'h4000_0000,
   parameter int     RANGE_PPM   = 65,
   parameter int     KP_SH       = 8,
   parameter int     KI_SH       = 7,
   parameter bit     INTEG_EN    = 1'b1,
   parameter int     UPD_PERIOD  = 64
) (
   input  logic             wr_clk,
   input  logic             wr_rst_n,
   input  logic             wr_valid,
   input  logic [DW-1:0]    wr_data,
   output logic             wr_ovf,
   input  logic             rd_clk,
   input  logic             rd_rst_n,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic             rd_run,
   output logic             rd_udf,
   output logic [AW:0]      fill_level,
   output logic [ACC_W-1:0] tune_word,
   output logic             tune_load,
   output logic             nco_clk
);

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("nco_desync: AW must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("nco_desync: SYNC_STAGES must be at least 2");
   end
   if (ACC_W < 8 || ACC_W > 62) begin : g_bad_acc
      $error("nco_desync: ACC_W must lie in 8..62");
   end
   if (UPD_PERIOD < 2) begin : g_bad_upd
      $error("nco_desync: UPD_PERIOD must be at least 2");
   end
   if (NOM_TW <= 0 || NOM_TW >= (64'sd1 <<< (ACC_W - 1))) begin : g_bad_nom
      $error("nco_desync: NOM_TW must lie below half the accumulator range");
   end

   logic rd_tick;

   desync_afifo #(.DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_ovf(wr_ovf),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_tick(rd_tick),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_udf(rd_udf),
      .fill(fill_level));

   desync_loop #(.AW(AW), .ACC_W(ACC_W), .NOM_TW(NOM_TW), .RANGE_PPM(RANGE_PPM),
                 .KP_SH(KP_SH), .KI_SH(KI_SH), .INTEG_EN(INTEG_EN),
                 .UPD_PERIOD(UPD_PERIOD)) u_loop (
      .clk(rd_clk), .rst_n(rd_rst_n), .fill(fill_level), .run(rd_run),
      .tune_word(tune_word), .tune_load(tune_load));

   desync_nco #(.ACC_W(ACC_W)) u_nco (
      .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_run), .step(tune_word),
      .tick(rd_tick), .msb(nco_clk));

endmodule

// File: tb/tb_nco_desync.sv
`timescale 1ns/1ps
module tb_nco_desync;

   localparam int     DW    = 8;
   localparam int     AW    = 4;
   localparam int     MIDV  = 8;
   localparam int     ACC_W = 32;
   localparam longint NOM   = 64'h4000_0000;
   localparam int     KP    = 8;
   localparam int     KI    = 7;
   localparam int     UPD   = 64;
   localparam longint LIM   = (NOM * 65) / 1000000;

   logic             wr_clk = 0, rd_clk = 0;
   logic             wr_rst_n = 0, rd_rst_n = 0;
   logic             wr_valid = 0;
   logic [DW-1:0]    wr_data = '0;
   logic             wr_ovf, rd_valid, rd_run, rd_udf, tune_load, nco_clk;
   logic [DW-1:0]    rd_data;
   logic [AW:0]      fill_level;
   logic [ACC_W-1:0] tune_word;

   nco_desync dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ovf(wr_ovf), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_run(rd_run), .rd_udf(rd_udf), .fill_level(fill_level),
      .tune_word(tune_word), .tune_load(tune_load), .nco_clk(nco_clk));

   always #2 rd_clk = ~rd_clk;
   initial begin
      #1.3;
      forever #2 wr_clk = ~wr_clk;
   end

   int  m_checks = 0, m_errors = 0, s_checks = 0, s_errors = 0, w_errors = 0;
   bit  done = 0;
   int  wmode = 0;
   int  wlimit = 0;
   bit  chk_data = 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      s_checks++;
      if (!ok) begin
         s_errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // write stimulus: 0 idle, 1 bursts of 4 in 16, 2 continuous, 3 up to wlimit words
   initial begin
      int wsent = 0;
      int ph = 0;
      forever begin
         @(negedge wr_clk);
         if (!wr_rst_n) begin
            wsent = 0; ph = 0; wr_valid = 0;
         end else begin
            bit v;
            v = (wmode == 1) ? (ph % 16 < 4) : (wmode == 2) ? 1'b1 :
                (wmode == 3) ? (wsent < wlimit) : 1'b0;
            ph++;
            wr_valid = v;
            if (v) begin
               wr_data = wsent[7:0];
               wsent++;
            end
         end
      end
   end

   // read-side monitor with arithmetic model of the loop filter
   initial begin
      int     rseq = 0, since = 0, prev_fill = 0;
      bit     prev_run = 0;
      longint integ = 0, last_tw = NOM;
      forever begin
         @(negedge rd_clk);
         if (!rd_rst_n) begin
            rseq = 0; since = 0; integ = 0; last_tw = NOM; prev_run = 0;
         end else begin
            since++;
            if (rd_run && !prev_run) since = 0;
            if (!rd_run) begin
               m_checks++;
               if (rd_valid || tune_word != NOM[ACC_W-1:0]) begin
                  m_errors++;
                  $display("FAIL R2: idle valid=%0d tw=%0d expected valid=0 tw=%0d",
                           rd_valid, tune_word, NOM);
               end
            end
            if (rd_valid) begin
               if (chk_data) begin
                  m_checks++;
                  if (rd_data != rseq[7:0]) begin
                     m_errors++;
                     $display("FAIL R1: rd_data=%0d expected %0d", rd_data, rseq[7:0]);
                  end
               end
               rseq++;
            end
            if (tune_load) begin
               longint err, exp_tw;
               err   = longint'(prev_fill) - MIDV;
               integ = integ + err * (64'sd1 <<< KI);
               if (integ > LIM)  integ = LIM;
               if (integ < -LIM) integ = -LIM;
               exp_tw = NOM + err * (64'sd1 <<< KP) + integ;
               m_checks += 2;
               if (since != UPD) begin
                  m_errors++;
                  $display("FAIL R5: load spacing=%0d expected %0d", since, UPD);
               end
               if (longint'(tune_word) != exp_tw) begin
                  m_errors++;
                  $display("FAIL R6: tune_word=%0d expected %0d", tune_word, exp_tw);
               end
               since = 0;
            end else begin
               m_checks++;
               if (longint'(tune_word) != last_tw) begin
                  m_errors++;
                  $display("FAIL R7: tune_word=%0d expected %0d", tune_word, last_tw);
               end
            end
            last_tw  = longint'(tune_word);
            prev_run = rd_run;
         end
         prev_fill = int'(fill_level);
      end
   end

   task automatic wait_rd(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   task automatic do_reset();
      rd_rst_n = 0; wr_rst_n = 0; wmode = 0; wlimit = 0;
      wait_rd(10);
      chk(rd_valid == 0 && rd_run == 0 && tune_load == 0, "R11 outputs", rd_run, 0);
      chk(tune_word == NOM[ACC_W-1:0], "R11 tune_word", tune_word, NOM);
      chk(wr_ovf == 0 && rd_udf == 0, "R11 flags", {wr_ovf, rd_udf}, 0);
      chk(fill_level == 0 && nco_clk == 0, "R11 fill/nco", fill_level, 0);
      rd_rst_n = 1; wr_rst_n = 1;
      wait_rd(2);
   endtask

   initial begin
      do_reset();

      // hold-off: seven words must not start reading
      wmode = 3; wlimit = 7;
      wait_rd(40);
      chk(rd_run == 0, "R2 hold below half", rd_run, 0);
      chk(fill_level == 7, "R4 fill after 7 writes", fill_level, 7);
      wlimit = 8;
      wait_rd(12);
      chk(rd_run == 1, "R2 run at half", rd_run, 1);
      wmode = 1;

      // steady bursty stream matched to nominal rate
      wait_rd(20000);
      begin
         longint sum = 0;
         int     rises = 0;
         logic   prev = nco_clk;
         longint expn;
         for (int i = 0; i < 4000; i++) begin
            @(negedge rd_clk);
            if (nco_clk && !prev) rises++;
            prev = nco_clk;
            sum += longint'(tune_word);
         end
         expn = sum >>> ACC_W;
         chk(rises >= expn - 1 && rises <= expn + 1, "R3 tick rate", rises, expn);
      end
      chk(wr_ovf == 0, "R9 no overflow in steady run", wr_ovf, 0);
      chk(rd_udf == 0, "R10 no underflow in steady run", rd_udf, 0);
      chk(rd_run == 1, "R2 run stays", rd_run, 1);

      // starve the FIFO
      wmode = 0;
      wait_rd(400);
      chk(rd_udf == 1, "R10 underflow set", rd_udf, 1);
      chk(fill_level == 0, "R4 fill drains to zero", fill_level, 0);
      chk(longint'(tune_word) < NOM, "R6 low fill lowers rate", tune_word, NOM);
      wmode = 1;
      wait_rd(500);
      chk(rd_udf == 1, "R10 underflow sticky", rd_udf, 1);

      // flood the FIFO
      chk_data = 0;
      wmode = 2;
      wait_rd(25000);
      chk(wr_ovf == 1, "R9 overflow set", wr_ovf, 1);
      chk(longint'(tune_word) > NOM, "R6 high fill raises rate", tune_word, NOM);
      chk(longint'(tune_word) - NOM - LIM >= 0 &&
          longint'(tune_word) - NOM - LIM <= (8 <<< KP),
          "R8 integrator at clamp", longint'(tune_word) - NOM, LIM);
      wmode = 0;
      wait_rd(300);
      chk(wr_ovf == 1, "R9 overflow sticky", wr_ovf, 1);

      // reset clears all, then restart
      do_reset();
      chk_data = 1;
      wmode = 3; wlimit = 8;
      wait_rd(12);
      chk(rd_run == 1, "R11 restart after reset", rd_run, 1);
      wmode = 1;
      wait_rd(3000);
      chk(wr_ovf == 0, "R11 overflow stays clear", wr_ovf, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks",
               s_errors + m_errors + w_errors, s_checks + m_checks + (w_errors > 0 ? 1 : 0));
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         w_errors = 1;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks",
                  s_errors + m_errors + w_errors, s_checks + m_checks + 1);
         $finish;
      end
   end

endmodule